// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of an 8-bit successive-approximation converter that serves eight multiplexed analog inputs. A start request, accepted only while the sequencer is idle, captures the channel number and the clock-rate choice. The block then drives the multiplexer select and holds a sample phase. After that it walks a trial code from the most significant bit to the least significant bit. For each bit it reads one comparator input, which reports whether the sampled voltage is at or above the trial code presented on its output.

All timing is counted in conversion-clock periods. The conversion clock is an enable derived from the system clock: either every system cycle or every second one. The sample phase takes 12 periods. The 148 periods that follow are divided into eight equal trial slots of 18 periods each, which leaves 4 idle periods, so a conversion lasts 160 periods. When the conversion ends, the final code is written to the result register and a one-cycle done pulse and a one-cycle interrupt request are raised together.

Top module: `sar_seq`

## Requirements
- R1: After reset, busy, sampling, done and irq are 0, and trial_code, result and mux_sel are all zero.
- R2: A start accepted while idle latches chan_sel (0 to 7) onto mux_sel for the whole conversion. Changes on chan_sel during a conversion have no effect on mux_sel or on the result.
- R3: sampling is 1 from the first busy cycle until the end of conversion-clock period 11, so it covers the first 12 periods, and trial_code is zero throughout.
- R4: When sampling ends, trial_code becomes 80h. Each trial slot lasts 18 periods. At the last period of a slot, the bit under trial takes the value of cmp_hi (1 keeps the bit) and the next lower bit is set to 1. Bits are tried from bit 7 down to bit 0.
- R5: A conversion lasts 160 conversion-clock periods. busy is 1 for exactly that many periods and drops on the cycle where done rises.
- R6: clk_half = 0 makes one conversion-clock period equal one system cycle (busy lasts 160 cycles). clk_half = 1 makes it two system cycles (busy lasts 320 cycles). The value is captured at start.
- R7: done and irq are 1 for exactly one cycle, the cycle in which result first shows the new code. result holds its value until the next conversion ends.
- R8: A start request while busy is ignored. The running conversion keeps its channel and timing, and no extra conversion follows.
- R9: With an ideal comparator (cmp_hi = input >= trial_code), the result equals the integer input level, including the end codes 00h and FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request, accepted only when idle |
| chan_sel | input | 3 | Channel to convert, captured at start |
| clk_half | input | 1 | Conversion clock select: 0 = system clock, 1 = half rate |
| cmp_hi | input | 1 | Comparator result: 1 when input >= trial_code |
| mux_sel | output | 3 | Latched channel driving the analog multiplexer |
| sampling | output | 1 | High during the sample phase |
| trial_code | output | 8 | Current trial code presented to the DAC |
| busy | output | 1 | Conversion in progress |
| result | output | 8 | Last completed conversion code |
| done | output | 1 | One-cycle pulse when result updates |
| irq | output | 1 | One-cycle interrupt request with done |

## Verification
The bench targets the 00h and FFh end codes. A design that got the LSB decision or the setting of the next bit wrong would be stuck one code away from an end. Half-rate conversions are measured in system cycles, so a prescaler that is not cleared at start, or a rate that is read live instead of latched, shows up as a busy length other than 320. During a busy period the bench issues start pulses on a different channel with a different input level. A design that restarts or relatches would return the wrong code or stretch busy. Every cycle is compared against the reference model, so a sample phase or decision slot that is off by one period is caught at the exact cycle where it goes wrong.

// File: rtl/sar_pkg.sv
package sar_pkg;
  parameter int RES_BITS   = 8;
  parameter int NUM_CH     = 8;
  parameter int SAMPLE_PER = 12;
  parameter int CONV_PER   = 160;
endpackage

// File: rtl/sar_prescale.sv
module sar_prescale (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  input  logic half,
  output logic tick
);
  logic phase_q;

  always_ff @(posedge clk) begin
    if (rst || clr) phase_q <= 1'b0;
    else if (run)   phase_q <= ~phase_q;
  end

  assign tick = run && (!half || phase_q);
endmodule

// File: rtl/sar_timer.sv
module sar_timer #(
  parameter int RES_BITS   = 8,
  parameter int SAMPLE_PER = 12,
  parameter int CONV_PER   = 160
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clr,
  input  logic                        tick,
  output logic                        sample_end,
  output logic                        slot_end,
  output logic                        conv_end,
  output logic [$clog2(RES_BITS)-1:0] bit_idx
);
  localparam int SLOT   = (CONV_PER - SAMPLE_PER) / RES_BITS;
  localparam int CNT_W  = $clog2(CONV_PER + 1);
  localparam int SLOT_W = $clog2(SLOT + 1);
  localparam int BIT_W  = $clog2(RES_BITS);

  logic [CNT_W-1:0]  per_cnt;
  logic [SLOT_W-1:0] slot_cnt;
  logic              trial_on;

  assign sample_end = tick && (per_cnt == CNT_W'(SAMPLE_PER - 1));
  assign slot_end   = tick && trial_on && (slot_cnt == SLOT_W'(SLOT - 1));
  assign conv_end   = tick && (per_cnt == CNT_W'(CONV_PER - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      per_cnt  <= '0;
      slot_cnt <= '0;
      bit_idx  <= BIT_W'(RES_BITS - 1);
      trial_on <= 1'b0;
    end else if (tick) begin
      per_cnt <= per_cnt + 1'b1;
      if (sample_end) trial_on <= 1'b1;
      if (trial_on) begin
        if (slot_end) begin
          slot_cnt <= '0;
          if (bit_idx == '0) trial_on <= 1'b0;
          else               bit_idx  <= bit_idx - 1'b1;
        end else begin
          slot_cnt <= slot_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sar_trial.sv
module sar_trial #(
  parameter int RES_BITS = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clr,
  input  logic                        load_msb,
  input  logic                        decide,
  input  logic [$clog2(RES_BITS)-1:0] bit_idx,
  input  logic                        cmp,
  output logic [RES_BITS-1:0]         code
);
  localparam int BIT_W = $clog2(RES_BITS);

  for (genvar g = 0; g < RES_BITS; g++) begin : g_bit
    logic is_cur;
    logic is_next;
    assign is_cur  = (bit_idx == BIT_W'(g));
    if (g == RES_BITS - 1) begin : g_top
      assign is_next = 1'b0;
    end else begin : g_low
      assign is_next = (bit_idx == BIT_W'(g + 1));
    end

    always_ff @(posedge clk) begin
      if (rst || clr)    code[g] <= 1'b0;
      else if (load_msb) code[g] <= (g == RES_BITS - 1);
      else if (decide) begin
        if (is_cur)       code[g] <= cmp;
        else if (is_next) code[g] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int RES_BITS   = sar_pkg::RES_BITS,
  parameter int NUM_CH     = sar_pkg::NUM_CH,
  parameter int SAMPLE_PER = sar_pkg::SAMPLE_PER,
  parameter int CONV_PER   = sar_pkg::CONV_PER,
  localparam int CH_W      = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [CH_W-1:0]     chan_sel,
  input  logic                clk_half,
  input  logic                cmp_hi,
  output logic [CH_W-1:0]     mux_sel,
  output logic                sampling,
  output logic [RES_BITS-1:0] trial_code,
  output logic                busy,
  output logic [RES_BITS-1:0] result,
  output logic                done,
  output logic                irq
);
  localparam int BIT_W = $clog2(RES_BITS);

  logic             go;
  logic             half_q;
  logic             tick;
  logic             sample_end;
  logic             slot_end;
  logic             conv_end;
  logic [BIT_W-1:0] bit_idx;

  assign go = start && !busy;

  sar_prescale u_pre (
    .clk  (clk),
    .rst  (rst),
    .clr  (go),
    .run  (busy),
    .half (half_q),
    .tick (tick)
  );

  sar_timer #(
    .RES_BITS   (RES_BITS),
    .SAMPLE_PER (SAMPLE_PER),
    .CONV_PER   (CONV_PER)
  ) u_tmr (
    .clk        (clk),
    .rst        (rst),
    .clr        (go),
    .tick       (tick),
    .sample_end (sample_end),
    .slot_end   (slot_end),
    .conv_end   (conv_end),
    .bit_idx    (bit_idx)
  );

  sar_trial #(
    .RES_BITS (RES_BITS)
  ) u_trial (
    .clk      (clk),
    .rst      (rst),
    .clr      (go),
    .load_msb (sample_end),
    .decide   (slot_end),
    .bit_idx  (bit_idx),
    .cmp      (cmp_hi),
    .code     (trial_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      half_q   <= 1'b0;
      mux_sel  <= '0;
      sampling <= 1'b0;
      result   <= '0;
      done     <= 1'b0;
      irq      <= 1'b0;
    end else begin
      done <= 1'b0;
      irq  <= 1'b0;
      if (go) begin
        busy     <= 1'b1;
        half_q   <= clk_half;
        mux_sel  <= chan_sel;
        sampling <= 1'b1;
      end else begin
        if (sample_end) sampling <= 1'b0;
        if (conv_end) begin
          busy   <= 1'b0;
          result <= trial_code;
          done   <= 1'b1;
          irq    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int RES_BITS = 8,
  parameter int CH_W     = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                start,
  input logic                busy,
  input logic                sampling,
  input logic                done,
  input logic                irq,
  input logic [CH_W-1:0]     mux_sel,
  input logic [RES_BITS-1:0] trial_code,
  input logic [RES_BITS-1:0] result
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R7
  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst) irq == done); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst) !done |-> $stable(result)); // R7
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst) done |-> !busy && $past(busy)); // R5
  AST_CH_STABLE: assert property (@(posedge clk) disable iff (rst) (busy && $past(busy)) |-> $stable(mux_sel)); // R2
  AST_SAMPLE_FIRST: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> sampling); // R3
  AST_SAMPLE_NO_TRIAL: assert property (@(posedge clk) disable iff (rst) sampling |-> trial_code == '0); // R3
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst) (busy && start && !done) |=> busy || done); // R8
endmodule

bind sar_seq sar_seq_chk #(.RES_BITS(RES_BITS), .CH_W(CH_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .busy       (busy),
  .sampling   (sampling),
  .done       (done),
  .irq        (irq),
  .mux_sel    (mux_sel),
  .trial_code (trial_code),
  .result     (result)
);

// File: tb/sar_seq_tb.sv
module sar_seq_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [2:0] chan_sel = '0;
  logic       clk_half = 1'b0;
  logic       cmp_hi;
  logic [2:0] mux_sel;
  logic       sampling;
  logic [7:0] trial_code;
  logic       busy;
  logic [7:0] result;
  logic       done;
  logic       irq;

  logic [7:0] vin [0:7];
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  assign cmp_hi = (int'(vin[mux_sel]) >= int'(trial_code));

  sar_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .chan_sel(chan_sel), .clk_half(clk_half),
    .cmp_hi(cmp_hi), .mux_sel(mux_sel), .sampling(sampling), .trial_code(trial_code),
    .busy(busy), .result(result), .done(done), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit m_busy, m_half, m_done;
  int m_phase, m_sub, m_ch, m_code, m_result;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_busy = 0; m_half = 0; m_done = 0;
      m_phase = 0; m_sub = 0; m_ch = 0; m_code = 0; m_result = 0;
    end else if (!m_busy) begin
      m_done = 0;
      if (start) begin
        m_busy = 1; m_phase = 0; m_sub = 0;
        m_half = clk_half; m_ch = int'(chan_sel); m_code = 0;
      end
    end else begin
      m_done = 0;
      m_sub++;
      if (m_sub == (m_half ? 2 : 1)) begin
        m_sub = 0;
        if (m_phase == 11) m_code = 128;
        else if (m_phase >= 12 && m_phase < 156 && ((m_phase - 12) % 18) == 17) begin
          int b;
          b = 7 - (m_phase - 12) / 18;
          if (int'(vin[m_ch]) >= m_code) m_code = m_code | (1 << b);
          else                           m_code = m_code & ~(1 << b);
          if (b > 0) m_code = m_code | (1 << (b - 1));
        end
        if (m_phase == 159) begin
          m_result = m_code; m_done = 1; m_busy = 0;
        end
        m_phase++;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(busy == m_busy, "R5 busy", busy, m_busy);
      chk(sampling == (m_busy && m_phase < 12), "R3 sampling", sampling, m_busy && m_phase < 12);
      chk(int'(trial_code) == m_code, "R4 trial_code", trial_code, m_code);
      chk(int'(result) == m_result, "R7 result", result, m_result);
      chk(done == m_done, "R7 done", done, m_done);
      chk(irq == m_done, "R7 irq", irq, m_done);
      chk(int'(mux_sel) == m_ch, "R2 mux_sel", mux_sel, m_ch);
    end
  end

  always @(posedge clk) begin
    if (cyc == 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic convert(input int ch, input bit half, input int disturb_ch,
                         input int exp_len, input string tag);
    int n;
    n = 0;
    @(negedge clk);
    chan_sel = 3'(ch); clk_half = half; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) begin
      if (busy) n++;
      if (disturb_ch >= 0 && n > 20 && n < 200) begin
        start = 1'b1; chan_sel = 3'(disturb_ch); clk_half = ~half;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(n == exp_len, {tag, " busy length"}, n, exp_len);
    chk(result == vin[ch], {tag, " result"}, result, vin[ch]);
    chk(irq == 1'b1, {tag, " irq pulse"}, irq, 1);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, {tag, " done one cycle, no restart"}, {done, busy}, 0);
  endtask

  initial begin
    vin[0] = 8'h00; vin[1] = 8'h01; vin[2] = 8'h80; vin[3] = 8'h5A;
    vin[4] = 8'h7F; vin[5] = 8'hA5; vin[6] = 8'h33; vin[7] = 8'hFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !sampling && !done && !irq, "R1 flags", {busy, sampling, done, irq}, 0);
    chk(trial_code == 0 && result == 0 && mux_sel == 0, "R1 data", {trial_code, result}, 0);
    // R9 main function and end codes, R5 length
    convert(3, 1'b0, -1, 160, "R9 ch3");
    convert(0, 1'b0, -1, 160, "R9 zero code");
    convert(7, 1'b0, -1, 160, "R9 full code");
    convert(1, 1'b0, -1, 160, "R9 lsb only");
    convert(4, 1'b0, -1, 160, "R9 7F");
    // R6 half-rate conversion clock
    convert(5, 1'b1, -1, 320, "R6 half rate");
    convert(2, 1'b1, -1, 320, "R6 half rate 80h");
    // R8 and R2: start and channel change while busy are ignored
    convert(6, 1'b0, 7, 160, "R8 R2 ignore restart");
    convert(5, 1'b1, 0, 320, "R8 R6 latched rate");
    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule